// File: doc/BRIEF.md
# NAND Asynchronous Strobe Sequencer

This block turns single host requests into bus cycles on an 8-bit asynchronous NAND flash interface. Each request names a cycle kind: command, address, data, or latch-only. The block raises the command latch line for command cycles and the address latch line for address cycles. It then walks chip enable and one of the two strobes (write or read) through a setup phase, a strobe phase, a hold phase and a turnaround gap. Separate timing fields cover the read direction and the write direction, and each phase is counted in interface clocks.

The timing word is sampled when a request is accepted, so the host may rewrite it while a cycle is in flight. Read data is captured on the last clock of the read strobe and is presented with a one-cycle valid pulse. The flash ready/busy line passes through a two-stage synchronizer and comes out as a status bit.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: While reset is asserted, chip enable, write strobe and read strobe are all high (inactive), both latch lines are low, the data bus is not driven, busy and rd_valid are low and status_ready is 0.
- R2: A request with req_kind 1 (command) performs a write cycle whatever req_write says, with the command latch line high and the address latch line low from the cycle after acceptance until the next accepted request.
- R3: A request with req_kind 2 (address) performs a write cycle whatever req_write says, with the address latch line high and the command latch line low.
- R4: A request with req_kind 0 (data) drives both latch lines low; req_write 1 gives a write cycle and req_write 0 gives a read cycle. On a write cycle the request byte is driven on the bus, with output enable high, from setup through hold.
- R5: A write cycle holds chip enable low for (WS+1)+(WP+1)+(WH+1) clocks, where WS, WP and WH are fields [29:26], [25:20] and [19:17] of the timing word. The write strobe is low only in the middle WP+1 of those clocks. Chip enable is then high for TA+1 turnaround clocks, where TA is field [3:2]. A field of 0 still gives one clock.
- R6: A read cycle uses RS, RP and RH from fields [16:13], [12:7] and [6:4] in the same way with the read strobe. The bus value is captured at the clock edge that ends the last read-strobe clock, and rd_valid is high for exactly the following cycle with that value on rd_data.
- R7: busy rises in the cycle after a bus-cycle request is accepted and falls after the last turnaround clock. A request is accepted only at an edge where busy is low, and requests presented while busy is high are dropped.
- R8: A request with req_kind 3 (latch-only) sets the command latch line to req_wdata[0] and the address latch line to req_wdata[1] from the next cycle. It produces no strobe and no chip enable, and busy stays low.
- R9: status_ready follows the flash ready input (1 = ready) two clock edges later.
- R10: Timing word bits [31:30] and [1:0] have no effect. The timing fields are taken at acceptance, so changing the word during a cycle does not alter that cycle.
- R11: The write strobe and the read strobe are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_timing | input | 32 | Phase timing word |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 data, 1 command, 2 address, 3 latch-only |
| req_write | input | 1 | Direction for data requests (1 = write) |
| req_wdata | input | 8 | Byte to write, or latch bits for latch-only requests |
| busy | output | 1 | Bus cycle in progress |
| rd_data | output | 8 | Last captured read byte |
| rd_valid | output | 1 | One-cycle pulse for new rd_data |
| status_ready | output | 1 | Synchronized flash ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus value to drive |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus value from the flash |
| nand_rdy | input | 1 | Flash ready/busy line, 1 = ready |

## Verification
A change of the flash ready line can land on the same edge as the end of a read strobe. Both the status synchronizer and the read-data register then move at once. The bench drives the bus input with a new value every clock and toggles the ready line on a free-running pattern throughout the read cycles, so these coincidences occur repeatedly. A behavioural model predicts the captured byte and the status bit separately for every clock, and both are compared on every cycle. A capture taken one edge early or late, or a lost ready update, shows up as a mismatch on that cycle.

// File: rtl/nand_strobe_ctrl.sv
`timescale 1ns/1ps
module nand_strobe_ctrl #(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_timing,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              status_ready,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rdy
);
  localparam int WS_LSB = 26, WS_W = 4;
  localparam int WP_LSB = 20, WP_W = 6;
  localparam int WH_LSB = 17, WH_W = 3;
  localparam int RS_LSB = 13, RS_W = 4;
  localparam int RP_LSB = 7,  RP_W = 6;
  localparam int RH_LSB = 4,  RH_W = 3;
  localparam int TA_LSB = 2,  TA_W = 2;
  localparam int CNT_W  = (WP_W > RP_W) ? WP_W : RP_W;

  localparam logic [1:0] K_DATA = 2'd0, K_CMD = 2'd1, K_ADDR = 2'd2, K_LATCH = 2'd3;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_TURN} phase_t;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt, lim;
  logic [CNT_W-1:0]   setup_q, strobe_q, hold_q, turn_q;
  logic               wr_q, cle_q, ale_q, rdy_s1, rdy_s2;
  logic [DATA_W-1:0]  wd_q;

  wire unused_cfg = ^{cfg_timing[31:30], cfg_timing[1:0]};

  wire idle     = (phase == PH_IDLE);
  wire take     = req_valid && idle;
  wire bus_take = take && (req_kind != K_LATCH);
  wire eff_wr   = req_write || (req_kind != K_DATA);
  wire active   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

  always_comb begin
    case (phase)
      PH_SETUP:  lim = setup_q;
      PH_STROBE: lim = strobe_q;
      PH_HOLD:   lim = hold_q;
      PH_TURN:   lim = turn_q;
      default:   lim = '0;
    endcase
  end

  wire last    = (cnt == lim);
  wire cap_now = (phase == PH_STROBE) && last && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      setup_q  <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
      turn_q   <= '0;
    end else if (bus_take) begin
      phase    <= PH_SETUP;
      cnt      <= '0;
      wr_q     <= eff_wr;
      wd_q     <= req_wdata;
      setup_q  <= eff_wr ? CNT_W'(cfg_timing[WS_LSB +: WS_W]) : CNT_W'(cfg_timing[RS_LSB +: RS_W]);
      strobe_q <= eff_wr ? CNT_W'(cfg_timing[WP_LSB +: WP_W]) : CNT_W'(cfg_timing[RP_LSB +: RP_W]);
      hold_q   <= eff_wr ? CNT_W'(cfg_timing[WH_LSB +: WH_W]) : CNT_W'(cfg_timing[RH_LSB +: RH_W]);
      turn_q   <= CNT_W'(cfg_timing[TA_LSB +: TA_W]);
    end else if (!idle) begin
      if (last) begin
        cnt <= '0;
        case (phase)
          PH_SETUP:  phase <= PH_STROBE;
          PH_STROBE: phase <= PH_HOLD;
          PH_HOLD:   phase <= PH_TURN;
          default:   phase <= PH_IDLE;
        endcase
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cle_q <= 1'b0;
      ale_q <= 1'b0;
    end else if (take) begin
      if (req_kind == K_LATCH) begin
        cle_q <= req_wdata[0];
        ale_q <= req_wdata[1];
      end else begin
        cle_q <= (req_kind == K_CMD);
        ale_q <= (req_kind == K_ADDR);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rdy_s1   <= 1'b0;
      rdy_s2   <= 1'b0;
    end else begin
      rd_valid <= cap_now;
      if (cap_now) rd_data <= nand_dq_in;
      rdy_s1 <= nand_rdy;
      rdy_s2 <= rdy_s1;
    end
  end

  assign busy         = !idle;
  assign status_ready = rdy_s2;
  assign nand_ce_n    = !active;
  assign nand_we_n    = !((phase == PH_STROBE) && wr_q);
  assign nand_re_n    = !((phase == PH_STROBE) && !wr_q);
  assign nand_dq_oe   = active && wr_q;
  assign nand_dq_out  = wd_q;
  assign nand_cle     = cle_q;
  assign nand_ale     = ale_q;

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe));

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind != K_LATCH) |=> busy);

  assert_latch_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == K_LATCH) |=> (!busy && nand_ce_n));

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_ce_n |-> !(nand_cle && nand_ale));

  assert_read_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (nand_re_n && $past(!nand_re_n)));
endmodule

// File: tb/sim_nand_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_nand_strobe_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [31:0] cfg_timing;
  logic        req_valid, req_write;
  logic [1:0]  req_kind;
  logic [7:0]  req_wdata;
  logic        busy, rd_valid, status_ready;
  logic [7:0]  rd_data, nand_dq_out, nand_dq_in;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rdy;

  nand_strobe_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_timing(cfg_timing),
    .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid), .status_ready(status_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy)
  );

  typedef struct packed {
    logic busy, cap, ce_n, we_n, re_n, cle, ale, oe;
    logic [7:0] dq;
  } exp_t;

  int checks = 0, failures = 0, cyc = 0;
  bit run_chk = 0, rdy_auto = 0;
  exp_t q[$];
  exp_t cur;
  logic m_cle, m_ale, m_s1, m_s2, m_rdv;
  logic [7:0] m_rd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic exp_t mk(input bit b, input bit cp, input bit ce, input bit we,
                              input bit re, input bit oe, input logic [7:0] d);
    exp_t e;
    e.busy = b; e.cap = cp; e.ce_n = ce; e.we_n = we; e.re_n = re;
    e.cle = m_cle; e.ale = m_ale; e.oe = oe; e.dq = d;
    return e;
  endfunction

  // behavioural reference: one queue entry per clock of the bus cycle
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete();
      m_cle = 0; m_ale = 0; m_s1 = 0; m_s2 = 0; m_rdv = 0; m_rd = 0;
      cur = mk(0, 0, 1, 1, 1, 0, 8'h00);
    end else begin
      m_s2 = m_s1;
      m_s1 = nand_rdy;
      if (cur.cap) begin m_rdv = 1; m_rd = nand_dq_in; end
      else m_rdv = 0;
      if (q.size() == 0 && !cur.busy && req_valid) begin
        if (req_kind == 2'd3) begin
          m_cle = req_wdata[0];
          m_ale = req_wdata[1];
        end else begin
          bit wr;
          int s, p, h, t;
          wr = req_write || (req_kind != 2'd0);
          m_cle = (req_kind == 2'd1);
          m_ale = (req_kind == 2'd2);
          s = wr ? int'(cfg_timing[29:26]) : int'(cfg_timing[16:13]);
          p = wr ? int'(cfg_timing[25:20]) : int'(cfg_timing[12:7]);
          h = wr ? int'(cfg_timing[19:17]) : int'(cfg_timing[6:4]);
          t = int'(cfg_timing[3:2]);
          for (int i = 0; i <= s; i++) q.push_back(mk(1, 0, 0, 1, 1, wr, req_wdata));
          for (int i = 0; i <= p; i++) q.push_back(mk(1, !wr && (i == p), 0, !wr, wr, wr, req_wdata));
          for (int i = 0; i <= h; i++) q.push_back(mk(1, 0, 0, 1, 1, wr, req_wdata));
          for (int i = 0; i <= t; i++) q.push_back(mk(1, 0, 1, 1, 1, 0, req_wdata));
        end
      end
      if (q.size() != 0) cur = q.pop_front();
      else cur = mk(0, 0, 1, 1, 1, 0, 8'h00);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk(nand_ce_n == cur.ce_n, "R5 ce_n", nand_ce_n, cur.ce_n);
      chk(nand_we_n == cur.we_n, "R5 we_n", nand_we_n, cur.we_n);
      chk(nand_re_n == cur.re_n, "R6 re_n", nand_re_n, cur.re_n);
      chk(nand_cle == cur.cle, "R2 cle", nand_cle, cur.cle);
      chk(nand_ale == cur.ale, "R3 ale", nand_ale, cur.ale);
      chk(busy == cur.busy, "R7 busy", busy, cur.busy);
      chk(nand_dq_oe == cur.oe, "R4 dq_oe", nand_dq_oe, cur.oe);
      if (cur.oe) chk(nand_dq_out == cur.dq, "R4 dq_out", nand_dq_out, cur.dq);
      chk(rd_valid == m_rdv, "R6 rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk(rd_data == m_rd, "R6 rd_data", rd_data, m_rd);
      chk(status_ready == m_s2, "R9 status_ready", status_ready, m_s2);
      chk(!(!nand_we_n && !nand_re_n), "R11 both strobes low", {nand_we_n, nand_re_n}, 2'b11);
    end
  end

  // bus input changes every clock; ready line optionally toggles on a pattern
  always @(negedge clk) begin
    nand_dq_in = cyc[7:0] ^ 8'h5A;
    if (rdy_auto) nand_rdy = cyc[2] ^ cyc[4];
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // poke: 0 none, 1 rewrite timing word on 3rd busy clock, 2 spurious request while busy
  task automatic do_req(input logic [1:0] k, input bit w, input logic [7:0] d,
                        input int poke, output int n);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_write = w; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (busy) begin
      n++;
      if (poke == 1 && n == 3) cfg_timing = 32'h0000_0000;
      if (poke == 2 && n == 3) begin
        req_valid = 1; req_kind = 2'd1; req_write = 1; req_wdata = 8'hEE;
      end
      if (poke == 2 && n == 5) req_valid = 0;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] CFG_EX  = 32'h0432_229C;
  localparam logic [31:0] CFG_MAX = 32'h3FFF_FFFC;

  initial begin
    int n;
    rst_n = 0; cfg_timing = CFG_EX; req_valid = 0; req_kind = 0; req_write = 0;
    req_wdata = 0; nand_rdy = 0; nand_dq_in = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    chk(!nand_cle && !nand_ale, "R1 latch lines low", {nand_cle, nand_ale}, 0);
    chk(!busy && !rd_valid && !nand_dq_oe && !status_ready, "R1 flags low",
        {busy, rd_valid, nand_dq_oe, status_ready}, 0);
    rst_n = 1; run_chk = 1;
    @(negedge clk);

    // R9: two-edge synchronizer latency
    nand_rdy = 1;
    @(negedge clk);
    chk(status_ready == 0, "R9 after one edge", status_ready, 0);
    @(negedge clk);
    chk(status_ready == 1, "R9 after two edges", status_ready, 1);

    // R2: command forced to write; 12 busy clocks with example timing (R5)
    do_req(2'd1, 0, 8'h70, 0, n);
    chk(n == 12, "R5 command cycle length", n, 12);
    do_req(2'd2, 1, 8'h12, 0, n);  // R3
    rdy_auto = 1;
    do_req(2'd0, 0, 8'h00, 0, n);  // R4 / R6 read
    chk(n == 14, "R6 read cycle length", n, 14);
    do_req(2'd0, 1, 8'hA5, 0, n);  // R4 write
    do_req(2'd0, 0, 8'h00, 0, n);

    // R8: latch-only requests
    do_req(2'd3, 0, 8'h01, 0, n);
    chk(n == 0, "R8 no busy", n, 0);
    chk(nand_cle == 1 && nand_ale == 0 && nand_ce_n == 1, "R8 cle only",
        {nand_cle, nand_ale, nand_ce_n}, 3'b101);
    do_req(2'd3, 0, 8'h02, 0, n);
    chk(nand_cle == 0 && nand_ale == 1, "R8 ale only", {nand_cle, nand_ale}, 2'b01);

    // R5: zero fields still give one clock per phase
    cfg_timing = 32'h0;
    do_req(2'd0, 1, 8'h3C, 0, n);
    chk(n == 4, "R5 minimum write length", n, 4);
    do_req(2'd0, 0, 8'h00, 0, n);
    chk(n == 4, "R6 minimum read length", n, 4);

    // R10: largest fields, then the same with the ignored bits set
    cfg_timing = CFG_MAX;
    do_req(2'd0, 1, 8'hC3, 0, n);
    chk(n == 92, "R5 maximum write length", n, 92);
    cfg_timing = 32'hFFFF_FFFF;
    do_req(2'd0, 0, 8'h00, 0, n);
    chk(n == 92, "R10 ignored bits set, read length", n, 92);

    // R10: rewriting the timing word mid-cycle
    cfg_timing = CFG_EX;
    do_req(2'd0, 1, 8'h81, 1, n);
    chk(n == 12, "R10 mid-cycle rewrite", n, 12);

    // R7: requests while busy are dropped
    cfg_timing = CFG_EX;
    do_req(2'd0, 0, 8'h00, 2, n);
    chk(n == 14, "R7 spurious request ignored", n, 14);
    chk(!busy && nand_cle == 0, "R7 no follow-on cycle", {busy, nand_cle}, 0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule